// File: doc/BRIEF.md
# Change-of-State Edge Detector

This block watches a vector of already-synchronised input lines, grouped into eight-line banks, and records every transition it is told to care about. Each line has a sticky flag that is set when the line rises or falls and the matching direction is enabled for its bank. Any set flag raises a level interrupt. Software clears flags by writing ones over them.

There are two ways to reach the flags. A byte-wide register port gives one status byte per bank and one enable byte. A 32-bit path reads all four status bytes at once and clears any mix of them in a single write. The enable byte holds one rising-edge bit per bank in its low nibble and one falling-edge bit per bank in its high nibble. An optional synchroniser chain, whose depth is a parameter, sits in front of the edge comparison.

Top module: `cos_edge_monitor`

## Requirements
- R1: While reset is asserted, and right after it, every status flag, the enable byte and `irq_o` are 0.
- R2: A 0-to-1 change on line i sets flag i when enable bit b is 1, where b = i/8 is the bank. The flag shows up SYNC_STAGES+1 rising clock edges after the input changes.
- R3: A 1-to-0 change on line i sets flag i when enable bit b+4 is 1, with the same latency as R2.
- R4: An edge whose direction is not enabled for its bank leaves the flags unchanged. This includes an edge in a bank whose enable bits are all 0 while other banks are enabled.
- R5: A set flag stays set while no clear is applied to it, whatever the input line does afterwards.
- R6: A byte write to status offset 8+b clears flag 8*b+k for every data bit k written as 1. Bits written as 0 and other banks keep their flags.
- R7: `word_rdata_o` is the four status bytes in little-endian order: offset 8 in bits 7:0 up to offset 11 in bits 31:24. A word write clears every flag whose data bit is 1.
- R8: If an edge sets a flag in the same cycle that a clear targets that flag, the flag stays set.
- R9: Writing 0 to the enable byte stops new flags from being set but leaves flags that are already set unchanged.
- R10: `irq_o` is 1 exactly when at least one status flag is 1.
- R11: A byte read of offset 14 returns the last value written there. Other offsets outside 8..11 read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lines_i | input | 32 | Monitored input lines; bank b is bits 8b+7..8b |
| byte_addr_i | input | 4 | Byte register offset |
| byte_wr_i | input | 1 | Byte write strobe, taken at the clock edge |
| byte_wdata_i | input | 8 | Byte write data |
| byte_rdata_o | output | 8 | Byte read data for `byte_addr_i`, combinational |
| word_wr_i | input | 1 | 32-bit write-one-to-clear strobe for all status bytes |
| word_wdata_i | input | 32 | 32-bit clear mask |
| word_rdata_o | output | 32 | All status flags as one little-endian word |
| irq_o | output | 1 | Level interrupt, high while any flag is set |

## Verification
The bench hits a flag with an edge and a clear in the same cycle. A design that gives priority to the clear loses that event and reads 0 where 1 is expected. It turns off all enables while flags are set: a design that also clears flags on that write drops the interrupt too early, and one that keeps sampling edges picks up new flags. It drives edges in directions and banks that are not enabled, which catches a swapped nibble or a wrong bank index. Byte and word clears with sparse masks catch wrong lane order and clears that touch bits written as 0.

// File: rtl/cos_pkg.sv
package cos_pkg;

   localparam int unsigned BYTE_W = 8;

   typedef enum logic [1:0] {
      REG_NONE   = 2'd0,
      REG_STATUS = 2'd1,
      REG_ENABLE = 2'd2
   } cos_reg_kind_e;

   // Bank that owns a given line index.
   function automatic int unsigned bank_of(input int unsigned line);
      return line / BYTE_W;
   endfunction

endpackage

// File: rtl/cos_sync_edge.sv
module cos_sync_edge #(
   parameter int unsigned WIDTH       = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] rise_o,
   output logic [WIDTH-1:0] fall_o
);

   logic [WIDTH-1:0] synced;
   logic [WIDTH-1:0] prev_q;

   generate
      if (SYNC_STAGES == 0) begin : g_bypass
         assign synced = d_i;
      end else begin : g_chain
         logic [SYNC_STAGES-1:0][WIDTH-1:0] stage_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               stage_q <= '0;
            end else begin
               stage_q[0] <= d_i;
               for (int s = 1; s < int'(SYNC_STAGES); s++) begin
                  stage_q[s] <= stage_q[s-1];
               end
            end
         end
         assign synced = stage_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         prev_q <= '0;
      end else begin
         prev_q <= synced;
      end
   end

   assign rise_o = synced & ~prev_q;
   assign fall_o = ~synced & prev_q;

endmodule

// File: rtl/cos_reg_file.sv
module cos_reg_file
   import cos_pkg::*;
#(
   parameter int unsigned NUM_BANKS = 4,
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned STAT_BASE = 8,
   parameter int unsigned EN_ADDR   = 14,
   localparam int unsigned NUM_LINES = NUM_BANKS * BYTE_W
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic [ADDR_W-1:0]    byte_addr_i,
   input  logic                 byte_wr_i,
   input  logic [BYTE_W-1:0]    byte_wdata_i,
   output logic [BYTE_W-1:0]    byte_rdata_o,
   input  logic                 word_wr_i,
   input  logic [NUM_LINES-1:0] word_wdata_i,
   input  logic [NUM_LINES-1:0] flags_i,
   output logic [NUM_LINES-1:0] clr_o,
   output logic [NUM_BANKS-1:0] en_rise_o,
   output logic [NUM_BANKS-1:0] en_fall_o
);

   localparam int unsigned EN_PAD = BYTE_W - 2 * NUM_BANKS;

   logic [BYTE_W-1:0]    en_q;
   cos_reg_kind_e        kind;
   logic [NUM_BANKS-1:0] stat_hit;

   // Address decode: one hit per status byte lane.
   generate
      for (genvar b = 0; b < int'(NUM_BANKS); b++) begin : g_lane
         assign stat_hit[b] = (byte_addr_i == ADDR_W'(STAT_BASE + b));
         assign clr_o[b*BYTE_W +: BYTE_W] =
            ((byte_wr_i && stat_hit[b]) ? byte_wdata_i : '0) |
            (word_wr_i ? word_wdata_i[b*BYTE_W +: BYTE_W] : '0);
      end
   endgenerate

   always_comb begin
      if (|stat_hit) begin
         kind = REG_STATUS;
      end else if (byte_addr_i == ADDR_W'(EN_ADDR)) begin
         kind = REG_ENABLE;
      end else begin
         kind = REG_NONE;
      end
   end

   // Enable byte: rising enables in the low field, falling in the next.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_q <= '0;
      end else if (byte_wr_i && kind == REG_ENABLE) begin
         en_q <= byte_wdata_i;
      end
   end

   assign en_rise_o = en_q[NUM_BANKS-1:0];
   assign en_fall_o = en_q[2*NUM_BANKS-1:NUM_BANKS];

   generate
      if (EN_PAD > 0) begin : g_pad_used
         logic unused_pad;
         assign unused_pad = ^en_q[BYTE_W-1:2*NUM_BANKS];
      end
   endgenerate

   // Read mux.
   always_comb begin
      byte_rdata_o = '0;
      unique case (kind)
         REG_STATUS: begin
            for (int b = 0; b < int'(NUM_BANKS); b++) begin
               if (stat_hit[b]) begin
                  byte_rdata_o = flags_i[b*BYTE_W +: BYTE_W];
               end
            end
         end
         REG_ENABLE: byte_rdata_o = en_q;
         default:    byte_rdata_o = '0;
      endcase
   end

endmodule

// File: rtl/cos_flag_store.sv
module cos_flag_store #(
   parameter int unsigned WIDTH = 32
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] set_i,
   input  logic [WIDTH-1:0] clr_i,
   output logic [WIDTH-1:0] flags_o,
   output logic             any_o
);

   logic [WIDTH-1:0] flag_q;

   // A new edge outranks a clear of the same bit.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         flag_q <= '0;
      end else begin
         flag_q <= (flag_q & ~clr_i) | set_i;
      end
   end

   assign flags_o = flag_q;
   assign any_o   = |flag_q;

endmodule

// File: rtl/cos_edge_monitor.sv
module cos_edge_monitor
   import cos_pkg::*;
#(
   parameter int unsigned NUM_BANKS   = 4,
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned STAT_BASE   = 8,
   parameter int unsigned EN_ADDR     = 14,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned NUM_LINES  = NUM_BANKS * BYTE_W
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic [NUM_LINES-1:0] lines_i,
   input  logic [ADDR_W-1:0]    byte_addr_i,
   input  logic                 byte_wr_i,
   input  logic [BYTE_W-1:0]    byte_wdata_i,
   output logic [BYTE_W-1:0]    byte_rdata_o,
   input  logic                 word_wr_i,
   input  logic [NUM_LINES-1:0] word_wdata_i,
   output logic [NUM_LINES-1:0] word_rdata_o,
   output logic                 irq_o
);

   // Elaboration-time parameter checks.
   generate
      if (2 * NUM_BANKS > BYTE_W) begin : g_bad_banks
         $error("enable byte cannot hold two bits per bank");
      end
      if (STAT_BASE + NUM_BANKS > (1 << ADDR_W)) begin : g_bad_stat
         $error("status bytes exceed the address space");
      end
      if (EN_ADDR >= (1 << ADDR_W)) begin : g_bad_en
         $error("enable offset exceeds the address space");
      end
      if (EN_ADDR >= STAT_BASE && EN_ADDR < STAT_BASE + NUM_BANKS) begin : g_overlap
         $error("enable offset overlaps a status byte");
      end
   endgenerate

   logic [NUM_LINES-1:0] rise_v;
   logic [NUM_LINES-1:0] fall_v;
   logic [NUM_LINES-1:0] set_vec;
   logic [NUM_LINES-1:0] clr_vec;
   logic [NUM_LINES-1:0] flag_q;
   logic [NUM_BANKS-1:0] en_rise;
   logic [NUM_BANKS-1:0] en_fall;
   logic                 any_flag;

   cos_sync_edge #(
      .WIDTH       (NUM_LINES),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (lines_i),
      .rise_o (rise_v),
      .fall_o (fall_v)
   );

   // Per-bank qualification of edges by direction enables.
   generate
      for (genvar b = 0; b < int'(NUM_BANKS); b++) begin : g_qual
         assign set_vec[b*BYTE_W +: BYTE_W] =
            (rise_v[b*BYTE_W +: BYTE_W] & {BYTE_W{en_rise[b]}}) |
            (fall_v[b*BYTE_W +: BYTE_W] & {BYTE_W{en_fall[b]}});
      end
   endgenerate

   cos_reg_file #(
      .NUM_BANKS (NUM_BANKS),
      .ADDR_W    (ADDR_W),
      .STAT_BASE (STAT_BASE),
      .EN_ADDR   (EN_ADDR)
   ) u_regs (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .byte_addr_i  (byte_addr_i),
      .byte_wr_i    (byte_wr_i),
      .byte_wdata_i (byte_wdata_i),
      .byte_rdata_o (byte_rdata_o),
      .word_wr_i    (word_wr_i),
      .word_wdata_i (word_wdata_i),
      .flags_i      (flag_q),
      .clr_o        (clr_vec),
      .en_rise_o    (en_rise),
      .en_fall_o    (en_fall)
   );

   cos_flag_store #(
      .WIDTH (NUM_LINES)
   ) u_flags (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .set_i   (set_vec),
      .clr_i   (clr_vec),
      .flags_o (flag_q),
      .any_o   (any_flag)
   );

   assign word_rdata_o = flag_q;
   assign irq_o        = any_flag;

endmodule

// File: rtl/cos_edge_monitor_chk.sv
module cos_edge_monitor_chk #(
   parameter int unsigned NUM_BANKS = 4,
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned EN_ADDR   = 14,
   localparam int unsigned NUM_LINES = NUM_BANKS * 8
) (
   input logic                 clk_i,
   input logic                 rst_ni,
   input logic [ADDR_W-1:0]    byte_addr_i,
   input logic                 byte_wr_i,
   input logic [NUM_LINES-1:0] word_rdata_o,
   input logic                 irq_o,
   input logic [NUM_LINES-1:0] flags,
   input logic [NUM_LINES-1:0] set_vec,
   input logic [NUM_LINES-1:0] clr_vec,
   input logic [NUM_BANKS-1:0] en_rise,
   input logic [NUM_BANKS-1:0] en_fall
);

   // R1: held in reset means everything is clear
   always @(negedge clk_i) begin
      if (!rst_ni) begin
         p_reset_clear_r1: assert (word_rdata_o == '0 && irq_o == 1'b0 &&
                                   en_rise == '0 && en_fall == '0);
      end
   end

   // R4: a bank with no enables gains no new flags
   generate
      for (genvar b = 0; b < int'(NUM_BANKS); b++) begin : g_bank
         p_quiet_bank_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (en_rise[b] == 1'b0 && en_fall[b] == 1'b0) |=>
            ((flags[b*8 +: 8] & ~$past(flags[b*8 +: 8])) == '0));
      end
   endgenerate

   // R5: flags not being cleared persist
   p_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> ((flags & $past(flags & ~clr_vec)) == $past(flags & ~clr_vec)));

   // R6: a clear with no competing edge takes the flag down
   p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> ((flags & $past(clr_vec & ~set_vec)) == '0));

   // R7: the word view is the flag vector
   p_word_view_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      word_rdata_o == flags);

   // R8: a qualified edge always leaves its flag set
   p_edge_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> ((flags & $past(set_vec)) == $past(set_vec)));

   // R10: interrupt level tracks the flags
   p_irq_level_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o == (|flags));

   // R11: enable byte only moves on a write to its offset
   p_enable_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(byte_wr_i && byte_addr_i == ADDR_W'(EN_ADDR)) |=> $stable({en_fall, en_rise}));

endmodule

bind cos_edge_monitor cos_edge_monitor_chk #(
   .NUM_BANKS (NUM_BANKS),
   .ADDR_W    (ADDR_W),
   .EN_ADDR   (EN_ADDR)
) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .byte_addr_i  (byte_addr_i),
   .byte_wr_i    (byte_wr_i),
   .word_rdata_o (word_rdata_o),
   .irq_o        (irq_o),
   .flags        (flag_q),
   .set_vec      (set_vec),
   .clr_vec      (clr_vec),
   .en_rise      (en_rise),
   .en_fall      (en_fall)
);

// File: tb/sim_cos_edge_monitor.sv
`timescale 1ns/1ps
module sim_cos_edge_monitor;

   localparam int SYNC = 2;
   localparam int LAT  = SYNC + 1;

   logic        clk_i = 1'b0;
   logic        rst_ni = 1'b0;
   logic [31:0] lines = '0;
   logic [3:0]  byte_addr_i = '0;
   logic        byte_wr_i = 1'b0;
   logic [7:0]  byte_wdata_i = '0;
   logic [7:0]  byte_rdata_o;
   logic        word_wr_i = 1'b0;
   logic [31:0] word_wdata_i = '0;
   logic [31:0] word_rdata_o;
   logic        irq_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2 clk_i = ~clk_i;

   cos_edge_monitor #(.SYNC_STAGES(SYNC)) u0 (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .lines_i      (lines),
      .byte_addr_i  (byte_addr_i),
      .byte_wr_i    (byte_wr_i),
      .byte_wdata_i (byte_wdata_i),
      .byte_rdata_o (byte_rdata_o),
      .word_wr_i    (word_wr_i),
      .word_wdata_i (word_wdata_i),
      .word_rdata_o (word_rdata_o),
      .irq_o        (irq_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic byte_write(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk_i);
      byte_addr_i = a; byte_wdata_i = d; byte_wr_i = 1'b1;
      @(negedge clk_i);
      byte_wr_i = 1'b0;
   endtask

   task automatic byte_read(input logic [3:0] a, output logic [7:0] d);
      @(negedge clk_i);
      byte_addr_i = a;
      #1 d = byte_rdata_o;
   endtask

   task automatic word_clear(input logic [31:0] m);
      @(negedge clk_i);
      word_wdata_i = m; word_wr_i = 1'b1;
      @(negedge clk_i);
      word_wr_i = 1'b0;
   endtask

   // Change one line and wait until its flag (if any) is visible.
   task automatic drive_line(input int idx, input logic v);
      @(negedge clk_i);
      lines[idx] = v;
      repeat (LAT) @(posedge clk_i);
      @(negedge clk_i);
   endtask

   task automatic t_reset();
      logic [7:0] d;
      chk("R1 word after reset", word_rdata_o, 32'h0);
      chk("R1 irq after reset", {31'h0, irq_o}, 32'h0);
      byte_read(4'd14, d);
      chk("R1 enable after reset", {24'h0, d}, 32'h0);
   endtask

   task automatic t_enable_reg();
      logic [7:0] d;
      byte_write(4'd14, 8'hA5);
      byte_read(4'd14, d);
      chk("R11 enable readback", {24'h0, d}, 32'hA5);
      byte_write(4'd3, 8'hFF);
      byte_read(4'd3, d);
      chk("R11 unused offset reads 0", {24'h0, d}, 32'h0);
      byte_read(4'd14, d);
      chk("R11 enable unchanged by other write", {24'h0, d}, 32'hA5);
      byte_read(4'd12, d);
      chk("R11 offset 12 reads 0", {24'h0, d}, 32'h0);
      byte_write(4'd14, 8'h00);
   endtask

   task automatic t_rise();
      logic [7:0] d;
      byte_write(4'd14, 8'h0F);
      drive_line(9, 1'b1);
      chk("R2 rise sets bit 9", word_rdata_o, 32'h0000_0200);
      byte_read(4'd9, d);
      chk("R2 byte view offset 9", {24'h0, d}, 32'h02);
      chk("R10 irq high with flag", {31'h0, irq_o}, 32'h1);
      drive_line(9, 1'b0);
      chk("R4 fall ignored when only rise enabled", word_rdata_o, 32'h0000_0200);
      word_clear(32'hFFFF_FFFF);
      chk("R10 irq low after clear", {31'h0, irq_o}, 32'h0);
   endtask

   task automatic t_fall();
      logic [7:0] d;
      byte_write(4'd14, 8'hF0);
      drive_line(27, 1'b1);
      chk("R4 rise ignored when only fall enabled", word_rdata_o, 32'h0);
      drive_line(27, 1'b0);
      chk("R3 fall sets bit 27", word_rdata_o, 32'h0800_0000);
      byte_read(4'd11, d);
      chk("R3 byte view offset 11", {24'h0, d}, 32'h08);
      word_clear(32'hFFFF_FFFF);
   endtask

   task automatic t_bank_select();
      byte_write(4'd14, 8'h01);
      drive_line(8, 1'b1);
      chk("R4 bank 1 not enabled", word_rdata_o, 32'h0);
      drive_line(3, 1'b1);
      chk("R2 bank 0 enabled", word_rdata_o, 32'h0000_0008);
      word_clear(32'hFFFF_FFFF);
      drive_line(8, 1'b0);
      drive_line(3, 1'b0);
   endtask

   task automatic t_sticky();
      byte_write(4'd14, 8'hFF);
      drive_line(0, 1'b1);
      drive_line(0, 1'b0);
      repeat (5) @(negedge clk_i);
      chk("R5 flag sticks after line returns", word_rdata_o, 32'h0000_0001);
   endtask

   task automatic t_byte_clear();
      logic [7:0] d;
      @(negedge clk_i);
      lines[16] = 1'b1; lines[17] = 1'b1;
      repeat (LAT) @(posedge clk_i);
      @(negedge clk_i);
      chk("R2 two lines in bank 2", word_rdata_o, 32'h0003_0001);
      byte_write(4'd10, 8'h01);
      chk("R6 byte clear only bit 16", word_rdata_o, 32'h0002_0001);
      byte_write(4'd8, 8'h00);
      chk("R6 zero byte write clears nothing", word_rdata_o, 32'h0002_0001);
      byte_read(4'd10, d);
      chk("R6 byte view after clear", {24'h0, d}, 32'h02);
      word_clear(32'hFFFF_FFFF);
      chk("R7 word clear all", word_rdata_o, 32'h0);
   endtask

   task automatic t_word_clear();
      logic [7:0] d;
      @(negedge clk_i);
      lines[7] = 1'b1; lines[15] = 1'b1; lines[23] = 1'b1; lines[31] = 1'b1;
      repeat (LAT) @(posedge clk_i);
      @(negedge clk_i);
      chk("R7 word view of four lanes", word_rdata_o, 32'h8080_8080);
      byte_read(4'd11, d);
      chk("R7 top lane at offset 11", {24'h0, d}, 32'h80);
      word_clear(32'h0000_8080);
      chk("R7 word clear low lanes", word_rdata_o, 32'h8080_0000);
      word_clear(32'hFFFF_FFFF);
   endtask

   task automatic t_collision();
      drive_line(5, 1'b1);
      chk("R2 bit 5 set before collision", word_rdata_o, 32'h0000_0020);
      @(negedge clk_i);
      lines[5] = 1'b0;
      repeat (LAT - 1) @(posedge clk_i);
      if (LAT > 1) @(negedge clk_i);
      word_wdata_i = 32'h0000_0020; word_wr_i = 1'b1;
      @(posedge clk_i);
      @(negedge clk_i);
      word_wr_i = 1'b0;
      chk("R8 edge wins over clear", word_rdata_o, 32'h0000_0020);
      word_clear(32'h0000_0020);
      chk("R6 clear without edge", word_rdata_o, 32'h0);
   endtask

   task automatic t_disable();
      drive_line(12, 1'b1);
      chk("R2 bit 12 set", word_rdata_o, 32'h0000_1000);
      byte_write(4'd14, 8'h00);
      chk("R9 disable keeps flag", word_rdata_o, 32'h0000_1000);
      chk("R9 irq stays high", {31'h0, irq_o}, 32'h1);
      drive_line(12, 1'b0);
      drive_line(13, 1'b1);
      chk("R9 no new flags when disabled", word_rdata_o, 32'h0000_1000);
      word_clear(32'hFFFF_FFFF);
   endtask

   initial begin
      repeat (3) @(negedge clk_i);
      t_reset();
      rst_ni = 1'b1;
      @(negedge clk_i);
      t_reset();
      t_enable_reg();
      t_rise();
      t_fall();
      t_bank_select();
      t_sticky();
      t_byte_clear();
      t_word_clear();
      t_collision();
      t_disable();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk_i);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule